// File: doc/BRIEF.md
# Logic-BIST Sequencer with Count-Keyed Reseeding

This block runs a logic self-test on a single scan chain. After a start request it loads a seed into an on-chip pattern generator and feeds the generator's top bit into the chain while scan enable is high. It then drops scan enable for one capture clock, or for two back-to-back capture clocks when transition-fault mode is selected. With those two clocks the first captured response serves as the second pattern of a launch-on-capture pair. Bits leaving the chain during every shift cycle are folded into a multiple-input signature register.

Reseeding is keyed to the applied-pattern counter instead of the full generator state. A small parameter table lists counter values and an XOR mask for each. When the last capture clock of a pattern occurs with the counter at a listed value, the mask is XORed into the generator. The next pattern therefore starts from a chosen point in the sequence. The decoder only looks at a counter about log2 of the test length wide. When the programmed number of patterns has been applied, the chain is shifted out once more so that the final response is compacted. The block then raises done and holds the signature until it is started again.

Top module: `lbist_sequencer`

## Requirements
- R1: After reset, scan_en, test_mode, capture and done are 0, pat_count is 0 and signature is 0.
- R2: A start accepted in the idle or done state with a nonzero test_len begins shifting in the next cycle. Each pattern is shifted with scan_en=1 and test_mode=1 for exactly CHAIN_LEN consecutive cycles.
- R3: The generator is loaded with LFSR_SEED when start is accepted. scan_in is its most significant bit. Each shift cycle it steps to {s[W-2:0], ^(s & LFSR_TAPS)}, and outside shift cycles it holds.
- R4: In stuck-at mode (trans_mode=0) every pattern is followed by exactly one capture cycle with capture=1, scan_en=0 and test_mode=1.
- R5: In transition mode (trans_mode=1) every pattern is followed by exactly two consecutive capture cycles, with no shift between them.
- R6: pat_count rises by one at the last capture cycle of each pattern, so right after pattern p (counting from 0) it reads p+1.
- R7: Entry k of the reseed table occupies bits [k*CNT_W +: CNT_W] of RESEED_AT and bits [k*LFSR_W +: LFSR_W] of RESEED_MASK. If pat_count equals that entry's count during the last capture cycle, the generator is XORed with that mask, so the next pattern starts from the altered state. At any other count the generator is left as is.
- R8: The signature is cleared when start is accepted. Each cycle with scan_en=1 it steps to {m[W-2:0], ^(m & MISR_TAPS) ^ scan_out}.
- R9: Once pat_count reaches test_len, one further run of CHAIN_LEN shift cycles unloads the chain. done then rises with scan_en=0, test_mode=0 and capture=0, and the signature and done stay constant until the next start.
- R10: A start with test_len=0 clears the signature and enters the done state in the next cycle without any shift or capture.
- R11: test_len and trans_mode are taken when start is accepted. A start, or a change of either input, during a running test has no effect on that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (taken in idle or done state) |
| trans_mode | input | 1 | 1 selects two capture clocks per pattern |
| test_len | input | CNT_W | Number of patterns to apply |
| scan_out | input | 1 | Bit leaving the end of the scan chain |
| scan_in | output | 1 | Bit entering the scan chain |
| scan_en | output | 1 | Scan shift enable |
| test_mode | output | 1 | High while a test run is in progress |
| capture | output | 1 | High on capture clock cycles |
| done | output | 1 | Test finished, signature valid |
| pat_count | output | CNT_W | Patterns applied in the current run |
| signature | output | MISR_W | Compacted response |

## Verification
The bench keeps the default build: a 12-bit chain, an 8-bit generator, a 16-bit signature and a two-entry reseed table that fires after patterns 2 and 5. With an 8-pattern run, both table entries fire mid-run. A 1-pattern run and a 0-pattern run cover the short boundaries. Every scan_in bit is compared against a reference model, so a reseed at a wrong count or with a wrong mask shows up as a changed bit in the pattern that follows. Runs in both capture modes are compared against golden signatures from the same model, with the chain contents carried over from one run to the next.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPT,
        ST_UNLOAD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic scan_en;
        logic test_mode;
        logic capture;
        logic done;
    } ctl_t;

    function automatic ctl_t ctl_of(input seq_state_e st);
        ctl_t c;
        c.scan_en   = (st == ST_SHIFT) || (st == ST_UNLOAD);
        c.test_mode = (st == ST_SHIFT) || (st == ST_UNLOAD) || (st == ST_CAPT);
        c.capture   = (st == ST_CAPT);
        c.done      = (st == ST_DONE);
        return c;
    endfunction

endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
    parameter int W = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hC3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_seed,
    input  logic         advance,
    input  logic         mask_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst || load_seed) begin
            state <= SEED;
        end else if (advance) begin
            state <= {state[W-2:0], ^(state & TAPS)};
        end else if (mask_en) begin
            state <= state ^ mask;
        end
    end

    // R3: no step, no reseed and no load leaves the generator unchanged
    a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
        (!advance && !mask_en && !load_seed) |=> $stable(state));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int W = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] sig
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sig <= '0;
        end else if (step) begin
            sig <= {sig[W-2:0], (^(sig & TAPS)) ^ din};
        end
    end

    // R8: outside shift cycles the signature does not move
    a_r8_misr_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(sig));

endmodule

// File: rtl/lbist_seed_decode.sv
module lbist_seed_decode #(
    parameter int CW = 8,
    parameter int LW = 8,
    parameter int N  = 2,
    parameter logic [N*CW-1:0] AT   = {8'd5, 8'd2},
    parameter logic [N*LW-1:0] MASK = {8'h81, 8'h5A}
) (
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [LW-1:0] mask
);

    logic [N-1:0]  hit_v;
    logic [LW-1:0] mask_v [N];

    for (genvar k = 0; k < N; k++) begin : g_entry
        assign hit_v[k]  = (count == AT[k*CW +: CW]);
        assign mask_v[k] = hit_v[k] ? MASK[k*LW +: LW] : '0;
    end

    always_comb begin
        mask = '0;
        for (int k = 0; k < N; k++) begin
            mask = mask | mask_v[k];
        end
    end

    assign hit = |hit_v;

endmodule

// File: rtl/lbist_sequencer.sv
module lbist_sequencer
    import lbist_pkg::*;
#(
    parameter int CHAIN_LEN = 12,
    parameter int CNT_W     = 8,
    parameter int LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hC3,
    parameter int MISR_W    = 16,
    parameter logic [MISR_W-1:0] MISR_TAPS = 16'hB400,
    parameter int NUM_SEEDS = 2,
    parameter logic [NUM_SEEDS*CNT_W-1:0]  RESEED_AT   = {8'd5, 8'd2},
    parameter logic [NUM_SEEDS*LFSR_W-1:0] RESEED_MASK = {8'h81, 8'h5A}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              trans_mode,
    input  logic [CNT_W-1:0]  test_len,
    input  logic              scan_out,
    output logic              scan_in,
    output logic              scan_en,
    output logic              test_mode,
    output logic              capture,
    output logic              done,
    output logic [CNT_W-1:0]  pat_count,
    output logic [MISR_W-1:0] signature
);

    localparam int SH_W = $clog2(CHAIN_LEN + 1);
    localparam logic [SH_W-1:0] SH_LAST = SH_W'(CHAIN_LEN - 1);

    seq_state_e        state_q;
    logic [SH_W-1:0]   sh_q;
    logic              cap2_q;
    logic              trans_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              accept;
    logic              last_capt;
    logic              seed_hit;
    logic [LFSR_W-1:0] seed_mask;
    logic [LFSR_W-1:0] gen_state;
    ctl_t              ctl;

    assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign last_capt = (state_q == ST_CAPT) && (!trans_q || cap2_q);
    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign ctl       = ctl_of(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cap2_q  <= 1'b0;
            trans_q <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        len_q   <= test_len;
                        trans_q <= trans_mode;
                        sh_q    <= '0;
                        cap2_q  <= 1'b0;
                        state_q <= (test_len == '0) ? ST_DONE : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_q == SH_LAST) begin
                        sh_q    <= '0;
                        state_q <= ST_CAPT;
                    end else begin
                        sh_q <= sh_q + SH_W'(1);
                    end
                end
                ST_CAPT: begin
                    if (trans_q && !cap2_q) begin
                        cap2_q <= 1'b1;
                    end else begin
                        cap2_q  <= 1'b0;
                        cnt_q   <= cnt_inc;
                        state_q <= (cnt_inc == len_q) ? ST_UNLOAD : ST_SHIFT;
                    end
                end
                ST_UNLOAD: begin
                    if (sh_q == SH_LAST) begin
                        sh_q    <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        sh_q <= sh_q + SH_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lbist_seed_decode #(
        .CW   (CNT_W),
        .LW   (LFSR_W),
        .N    (NUM_SEEDS),
        .AT   (RESEED_AT),
        .MASK (RESEED_MASK)
    ) u_decode (
        .count (cnt_q),
        .hit   (seed_hit),
        .mask  (seed_mask)
    );

    lbist_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_gen (
        .clk       (clk),
        .rst       (rst),
        .load_seed (accept),
        .advance   (state_q == ST_SHIFT),
        .mask_en   (last_capt && seed_hit),
        .mask      (seed_mask),
        .state     (gen_state)
    );

    lbist_misr #(
        .W    (MISR_W),
        .TAPS (MISR_TAPS)
    ) u_sig (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (ctl.scan_en),
        .din   (scan_out),
        .sig   (signature)
    );

    assign scan_in   = gen_state[LFSR_W-1];
    assign scan_en   = ctl.scan_en;
    assign test_mode = ctl.test_mode;
    assign capture   = ctl.capture;
    assign done      = ctl.done;
    assign pat_count = cnt_q;

    // R4: a capture clock never overlaps shifting and stays inside test mode
    a_r4_capture_excl: assert property (@(posedge clk) disable iff (rst)
        capture |-> (!scan_en && test_mode));

    // R5: transition mode pairs capture clocks back to back
    a_r5_trans_pair: assert property (@(posedge clk) disable iff (rst)
        ($rose(capture) && trans_q) |=> capture);

    // R4: stuck-at mode uses a single capture clock
    a_r4_single_capture: assert property (@(posedge clk) disable iff (rst)
        (capture && !trans_q) |=> !capture);

    // R6: the pattern count only holds or steps by one while running
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (pat_count == $past(pat_count) ||
                     pat_count == CNT_W'($past(pat_count) + CNT_W'(1))));

    // R9: the finished state keeps its signature until restarted
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(signature)));

endmodule

// File: tb/lbist_sequencer_test.sv
module lbist_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int L      = 12;
    localparam int CNT_W  = 8;
    localparam int GW     = 8;
    localparam logic [GW-1:0] G_TAPS = 8'hB8;
    localparam logic [GW-1:0] G_SEED = 8'hC3;
    localparam int MW     = 16;
    localparam logic [MW-1:0] M_TAPS = 16'hB400;
    localparam int NS     = 2;
    localparam logic [NS*CNT_W-1:0] AT   = {8'd5, 8'd2};
    localparam logic [NS*GW-1:0]    MASK = {8'h81, 8'h5A};
    localparam logic [L-1:0] CUT_K = 12'hA5C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic trans_mode = 1'b0;
    logic [CNT_W-1:0] test_len = '0;
    logic scan_out, scan_in, scan_en, test_mode, capture, done;
    logic [CNT_W-1:0] pat_count;
    logic [MW-1:0] signature;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbist_sequencer #(
        .CHAIN_LEN (L), .CNT_W (CNT_W), .LFSR_W (GW), .LFSR_TAPS (G_TAPS),
        .LFSR_SEED (G_SEED), .MISR_W (MW), .MISR_TAPS (M_TAPS),
        .NUM_SEEDS (NS), .RESEED_AT (AT), .RESEED_MASK (MASK)
    ) uut (
        .clk (clk), .rst (rst), .start (start), .trans_mode (trans_mode),
        .test_len (test_len), .scan_out (scan_out), .scan_in (scan_in),
        .scan_en (scan_en), .test_mode (test_mode), .capture (capture),
        .done (done), .pat_count (pat_count), .signature (signature)
    );

    function automatic logic [L-1:0] cut_fn(input logic [L-1:0] x);
        return {x[L-2:0], x[L-1]} ^ (x & {x[0], x[L-1:1]}) ^ CUT_K;
    endfunction

    // placeholder scan chain and circuit under test
    logic [L-1:0] chain_q;
    always @(posedge clk) begin
        if (rst)          chain_q <= '0;
        else if (scan_en) chain_q <= {chain_q[L-2:0], scan_in};
        else if (capture) chain_q <= cut_fn(chain_q);
    end
    assign scan_out = chain_q[L-1];

    function automatic logic [GW-1:0] gen_step(input logic [GW-1:0] s);
        return {s[GW-2:0], ^(s & G_TAPS)};
    endfunction

    function automatic logic [MW-1:0] sig_step(input logic [MW-1:0] m, input logic d);
        return {m[MW-2:0], (^(m & M_TAPS)) ^ d};
    endfunction

    int n_total = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues
    logic         exp_bits[$];
    logic [MW-1:0] exp_sig[$];
    logic [L-1:0] model_chain = '0;

    bit mon_active = 0;
    bit done_seen = 0;
    int mon_len = 0;
    bit mon_trans = 0;
    int shift_run = 0;
    int cap_run = 0;
    int pats_seen = 0;

    // monitor
    always @(negedge clk) begin
        if (!rst && mon_active) begin
            if (cap_run > 0 && !capture) begin
                chk(shift_run == L, "R2", "shift run length", shift_run, L);
                chk(cap_run == (mon_trans ? 2 : 1), mon_trans ? "R5" : "R4",
                    "capture run length", cap_run, mon_trans ? 2 : 1);
                chk(pat_count == CNT_W'(pats_seen + 1), "R6", "pattern count",
                    pat_count, pats_seen + 1);
                pats_seen++;
                shift_run = 0;
                cap_run = 0;
            end
            if (capture) begin
                cap_run++;
                chk(!scan_en && test_mode, "R4", "capture control", {scan_en, test_mode}, 1);
            end
            if (scan_en) begin
                shift_run++;
                chk(test_mode == 1'b1, "R2", "test_mode during shift", test_mode, 1);
                if (pats_seen < mon_len) begin
                    if (exp_bits.size() == 0) begin
                        chk(0, "R3", "unexpected shift bit", 0, 1);
                    end else begin
                        logic b;
                        b = exp_bits.pop_front();
                        chk(scan_in == b, "R3 R7", "scan_in bit", scan_in, b);
                    end
                end
            end
            if (done) begin
                logic [MW-1:0] es;
                chk(shift_run == L, "R9", "unload length", shift_run, L);
                chk(pat_count == CNT_W'(mon_len), "R9", "final count", pat_count, mon_len);
                chk(exp_bits.size() == 0, "R7", "leftover pattern bits", exp_bits.size(), 0);
                es = (exp_sig.size() > 0) ? exp_sig.pop_front() : '0;
                chk(signature == es, "R8", "signature", signature, es);
                mon_active = 0;
                done_seen = 1;
            end
        end
    end

    task automatic run_case(input int len, input bit trans, input bit disturb);
        logic [GW-1:0] g;
        logic [L-1:0]  ch;
        logic [MW-1:0] m;
        logic [MW-1:0] held;
        g = G_SEED;
        ch = model_chain;
        m = '0;
        for (int p = 0; p < len; p++) begin
            for (int i = 0; i < L; i++) begin
                exp_bits.push_back(g[GW-1]);
                m = sig_step(m, ch[L-1]);
                ch = {ch[L-2:0], g[GW-1]};
                g = gen_step(g);
            end
            ch = cut_fn(ch);
            if (trans) ch = cut_fn(ch);
            for (int k = 0; k < NS; k++) begin
                if (p == int'(AT[k*CNT_W +: CNT_W])) g = g ^ MASK[k*GW +: GW];
            end
        end
        if (len > 0) begin
            for (int i = 0; i < L; i++) begin
                m = sig_step(m, ch[L-1]);
                ch = {ch[L-2:0], g[GW-1]};
            end
            exp_sig.push_back(m);
        end
        model_chain = ch;

        done_seen = 0; shift_run = 0; cap_run = 0; pats_seen = 0;
        mon_len = len; mon_trans = trans;
        @(negedge clk);
        start = 1'b1; test_len = CNT_W'(len); trans_mode = trans;
        @(posedge clk);
        #1;
        if (len > 0) mon_active = 1;
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            chk(done == 1'b1, "R10", "done after empty run", done, 1);
            chk(signature == '0, "R10", "signature cleared", signature, 0);
            chk(!scan_en && !capture, "R10", "no shift or capture", {scan_en, capture}, 0);
            chk(pat_count == '0, "R10", "count after empty run", pat_count, 0);
            repeat (3) @(negedge clk);
            chk(!scan_en && done, "R10", "still idle in done", {scan_en, done}, 1);
            return;
        end
        if (disturb) begin
            repeat (30) @(negedge clk);
            start = 1'b1; trans_mode = ~trans; test_len = 8'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        held = signature;
        repeat (4) @(negedge clk);
        chk(signature == held, "R9", "signature held", signature, held);
        chk(done && !scan_en && !test_mode && !capture, "R9", "done controls",
            {done, scan_en, test_mode, capture}, 4'b1000);
        if (disturb) begin
            chk(pat_count == CNT_W'(len), "R11", "count after ignored start", pat_count, len);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!scan_en && !test_mode && !capture && !done, "R1", "reset controls",
            {scan_en, test_mode, capture, done}, 0);
        chk(pat_count == '0, "R1", "reset count", pat_count, 0);
        chk(signature == '0, "R1", "reset signature", signature, 0);

        run_case(8, 1'b0, 1'b0);
        run_case(8, 1'b1, 1'b1);
        run_case(0, 1'b0, 1'b0);
        run_case(1, 1'b0, 1'b0);
        run_case(7, 1'b1, 1'b0);
        run_case(3, 1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule